// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block steers a vector of device interrupt request lines to up to four processors. Every processor owns an enable mask as wide as the request vector. The set of requests routed to a processor is its mask ANDed with the captured request vector. The processor's interrupt output is high while that routed set holds any bit. A single request line can therefore interrupt any number of processors at once, one for each mask that enables it.

Software uses a 64-bit register port. The register index is the byte offset divided by 64. Software can write the masks, and it can read the masks, the routed sets and the raw request vector. A non-64-bit access, a write to a read-only register, or an access to an unimplemented index raises a sticky error flag. Such an access changes no state, and if it is a read it returns zero. The port has no address decode to a base: `csrAddr` is the offset inside the block.

Top module: `irq_router`

## Requirements
- R1: After reset, all masks, the captured request vector, all routed sets, `cpuIrq`, `csrErr` and `csrRdata` are zero.
- R2: The routed set of processor n, read at register index 4+n, equals mask n ANDed with the captured request vector. The captured vector, read at index 8, is `devReq` as sampled at the previous clock edge.
- R3: A change on `devReq` reaches `cpuIrq` two clock edges later. A mask write reaches `cpuIrq` one edge after the write edge. `cpuIrq[n]` is high exactly when routed set n is nonzero.
- R4: A request line enabled in several masks asserts the outputs of all of those processors together. Removing the line from one mask deasserts only that processor's output.
- R5: Register index is `csrAddr` shifted right by 6, and the low six address bits are ignored. Indices 0..3 are the masks of processors 0..3, and these are read/write. Indices 4..7 are the routed sets and index 8 is the raw vector; these are read-only.
- R6: Read data appears on `csrRdata` after the clock edge that accepts the read and holds until the next read.
- R7: An access with `csrSize` other than 8 sets `csrErr`, changes no mask, and a read returns zero.
- R8: `csrErr` stays set until reset once set, and only reset clears it.
- R9: A write to a routed-set or raw-vector index sets `csrErr` and changes neither masks nor the captured vector.
- R10: An access to an index of 9 or above, or to a processor index at or beyond `NCPU`, sets `csrErr`, returns zero when read and leaves every mask unchanged.
- R11: A mask write and a request change in the same cycle both take effect at that edge. The output on the following edge reflects the new mask ANDed with the new requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devReq | input | NLINES | Raw device request lines |
| csrValid | input | 1 | Register access strobe, one cycle |
| csrWrite | input | 1 | 1 = write, 0 = read |
| csrAddr | input | ADDR_W | Byte offset inside the block |
| csrSize | input | 4 | Access size in bytes; only 8 is legal |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Registered read data |
| csrErr | output | 1 | Sticky access error flag |
| cpuIrq | output | NCPU | Per-processor device interrupt |

## Verification
A mask write and a change of the request lines can land on the same clock edge. Both update registers that feed the same AND. The bench drives a mask write and a new request vector on the same cycle, once raising and once dropping the shared line. One edge later it compares every processor's output with the new mask ANDed with the new vector. Beside this, it sweeps each single request line against fixed, overlapping masks and runs a pseudo-random series of multi-bit vectors. Expected outputs and routed reads are computed arithmetically.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int MAX_CPUS = 4;
  localparam int DATA_W   = 64;

  typedef enum logic [1:0] {RD_ZERO, RD_MASK, RD_ROUTED, RD_RAW} rdKind_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic        maskWe;
    logic [1:0]  cpuSel;
    logic        rdEn;
    rdKind_e     rdKind;
    logic        accErr;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_router_ctl.sv
module irq_router_ctl
  import irq_router_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrValid,
  input  logic              csrWrite,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [3:0]        csrSize,
  output ctlStrobe_t        strb,
  output logic              csrErr
);
  localparam int IDX_W = ADDR_W - 6;

  logic [IDX_W-1:0] idx;
  int               idxI;

  assign idx  = csrAddr[ADDR_W-1:6];
  assign idxI = int'(idx);

  always_comb begin
    strb        = '0;
    strb.rdKind = RD_ZERO;
    if (csrValid) begin
      strb.rdEn   = !csrWrite;
      strb.cpuSel = idx[1:0];
      if (csrSize != 4'd8) begin
        strb.accErr = 1'b1;
      end else if (idxI < MAX_CPUS && idxI < NCPU) begin
        if (csrWrite) strb.maskWe = 1'b1;
        else          strb.rdKind = RD_MASK;
      end else if (idxI >= MAX_CPUS && idxI < 2*MAX_CPUS && (idxI - MAX_CPUS) < NCPU) begin
        if (csrWrite) strb.accErr = 1'b1;
        else          strb.rdKind = RD_ROUTED;
      end else if (idxI == 2*MAX_CPUS) begin
        if (csrWrite) strb.accErr = 1'b1;
        else          strb.rdKind = RD_RAW;
      end else begin
        strb.accErr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            csrErr <= 1'b0;
    else if (strb.accErr) csrErr <= 1'b1;
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int NLINES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [DATA_W-1:0] csrWdata,
  input  logic [NLINES-1:0] devReq,
  output logic [DATA_W-1:0] csrRdata,
  output logic [NCPU-1:0]   cpuIrq
);
  logic [NLINES-1:0] rawQ;
  logic [NLINES-1:0] maskQ   [NCPU];
  logic [NLINES-1:0] routedV [NCPU];
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= devReq;
  end

  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        maskQ[n] <= '0;
      else if (strb.maskWe && strb.cpuSel == 2'(n))
        maskQ[n] <= csrWdata[NLINES-1:0];
    end

    assign routedV[n] = maskQ[n] & rawQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cpuIrq[n] <= 1'b0;
      else       cpuIrq[n] <= |routedV[n];
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strb.rdKind)
      RD_MASK:   rdNext = DATA_W'(maskQ[strb.cpuSel]);
      RD_ROUTED: rdNext = DATA_W'(routedV[strb.cpuSel]);
      RD_RAW:    rdNext = DATA_W'(rawQ);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          csrRdata <= '0;
    else if (strb.rdEn) csrRdata <= rdNext;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int NLINES = 64,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NLINES-1:0] devReq,
  input  logic              csrValid,
  input  logic              csrWrite,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [3:0]        csrSize,
  input  logic [63:0]       csrWdata,
  output logic [63:0]       csrRdata,
  output logic              csrErr,
  output logic [NCPU-1:0]   cpuIrq
);
  ctlStrobe_t strb;

  irq_router_ctl #(.NCPU(NCPU), .ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite),
    .csrAddr(csrAddr), .csrSize(csrSize), .strb(strb), .csrErr(csrErr)
  );

  irq_router_dp #(.NCPU(NCPU), .NLINES(NLINES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .csrWdata(csrWdata),
    .devReq(devReq), .csrRdata(csrRdata), .cpuIrq(cpuIrq)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NCPU   = 4,
  parameter int NLINES = 64,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [NLINES-1:0] devReq,
  input logic              csrValid,
  input logic              csrWrite,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [3:0]        csrSize,
  input logic [63:0]       csrRdata,
  input logic              csrErr,
  input logic [NCPU-1:0]   cpuIrq
);
  int idxC;
  assign idxC = int'(csrAddr[ADDR_W-1:6]);

  // R3: two quiet request cycles leave every output low
  p_quiet_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(devReq, 1) == '0 && $past(devReq, 2) == '0) |-> cpuIrq == '0);

  // R7: a narrow access raises the error flag
  p_narrow_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrSize != 4'd8) |=> csrErr);

  // R7: a narrow read returns zero
  p_narrow_rd_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && !csrWrite && csrSize != 4'd8) |=> csrRdata == '0);

  // R8: the error flag never drops without reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    csrErr |=> csrErr);

  // R9: a write to a read-only index raises the error flag
  p_ro_write_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && csrWrite && idxC >= 4 && idxC <= 8) |=> csrErr);

  // R10: a reserved-index read returns zero
  p_reserved_rd_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csrValid && !csrWrite && idxC >= 9) |=> (csrRdata == '0 && csrErr));
endmodule

bind irq_router irq_router_chk #(.NCPU(NCPU), .NLINES(NLINES), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
  localparam int NCPU   = 4;
  localparam int NLINES = 64;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NLINES-1:0] devReq;
  logic              csrValid, csrWrite;
  logic [ADDR_W-1:0] csrAddr;
  logic [3:0]        csrSize;
  logic [63:0]       csrWdata, csrRdata;
  logic              csrErr;
  logic [NCPU-1:0]   cpuIrq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [63:0] maskM [NCPU];
  logic [63:0] rd;
  logic [63:0] lcg;

  always #5 clk = ~clk;

  irq_router #(.NCPU(NCPU), .NLINES(NLINES), .ADDR_W(ADDR_W)) dut_i (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input int idx, input logic [5:0] lo,
                     input logic [3:0] sz, input logic [63:0] wd, output logic [63:0] r);
    @(negedge clk);
    csrValid = 1'b1; csrWrite = wr; csrAddr = {4'(idx), lo};
    csrSize = sz; csrWdata = wd;
    @(negedge clk);
    csrValid = 1'b0; csrWrite = 1'b0;
    r = csrRdata;
  endtask

  task automatic setReq(input logic [63:0] v);
    @(negedge clk); devReq = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NCPU-1:0] expIrq(input logic [63:0] req);
    logic [NCPU-1:0] e;
    for (int n = 0; n < NCPU; n++) e[n] = |(maskM[n] & req);
    return e;
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; devReq = '0; csrValid = 0; csrWrite = 0;
    csrAddr = '0; csrSize = 4'd8; csrWdata = '0;
    doReset();

    // R1: reset state
    check("R1 cpuIrq", 64'(cpuIrq), 0);
    check("R1 csrErr", 64'(csrErr), 0);
    check("R1 csrRdata", csrRdata, 0);
    for (int i = 0; i < 9; i++) begin
      acc(0, i, 6'd0, 4'd8, 0, rd);
      check($sformatf("R1 reg%0d", i), rd, 0);
    end

    // R5: mask writes with nonzero low offset bits, read back aligned
    for (int n = 0; n < NCPU; n++) begin
      maskM[n] = (64'h9E3779B97F4A7C15 >> (n * 5)) ^ (64'hFFFF << (n * 16));
      acc(1, n, 6'h15, 4'd8, maskM[n], rd);
    end
    for (int n = 0; n < NCPU; n++) begin
      acc(0, n, 6'h00, 4'd8, 0, rd);
      check($sformatf("R5 mask%0d", n), rd, maskM[n]);
    end

    // R2/R3: single-line sweep over all request bits
    for (int b = 0; b < NLINES; b++) begin
      logic [63:0] req;
      req = 64'h1 << b;
      setReq(req);
      check($sformatf("R3 irq bit%0d", b), 64'(cpuIrq), 64'(expIrq(req)));
      acc(0, 4 + (b % NCPU), 6'd0, 4'd8, 0, rd);
      check($sformatf("R2 routed bit%0d", b), rd, maskM[b % NCPU] & req);
      acc(0, 8, 6'd0, 4'd8, 0, rd);
      check($sformatf("R2 raw bit%0d", b), rd, req);
      // R6: read data holds until the next read
      @(negedge clk);
      check("R6 hold", csrRdata, req);
    end

    // R2/R3: pseudo-random multi-bit vectors
    lcg = 64'h0123456789ABCDEF;
    for (int k = 0; k < 24; k++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      setReq(lcg & (lcg >> 7) & (lcg >> 13));
      check("R3 irq multi", 64'(cpuIrq), 64'(expIrq(devReq)));
      for (int n = 0; n < NCPU; n++) begin
        acc(0, 4 + n, 6'h3F, 4'd8, 0, rd);
        check("R2 routed multi", rd, maskM[n] & devReq);
      end
    end

    // R4: shared line reaches all processors; remove one
    for (int n = 0; n < NCPU; n++) begin
      maskM[n] = 64'h1 << 40;
      acc(1, n, 6'd0, 4'd8, maskM[n], rd);
    end
    setReq(64'h1 << 40);
    check("R4 all", 64'(cpuIrq), 64'hF);
    maskM[2] = 0;
    acc(1, 2, 6'd0, 4'd8, 0, rd);
    check("R3 mask edge not yet", 64'(cpuIrq), 64'hF);
    @(negedge clk);
    check("R4 one removed", 64'(cpuIrq), 64'hB);

    // R11: mask write and request change on the same edge
    maskM[0] = '1; maskM[3] = '1;
    acc(1, 0, 6'd0, 4'd8, '1, rd);
    acc(1, 3, 6'd0, 4'd8, '1, rd);
    @(negedge clk);
    devReq = 64'h8;
    csrValid = 1; csrWrite = 1; csrAddr = {4'd1, 6'd0}; csrSize = 4'd8; csrWdata = 64'h8;
    @(negedge clk); csrValid = 0; csrWrite = 0;
    @(negedge clk);
    check("R11 rise", 64'(cpuIrq), 64'b1011);
    devReq = 64'h0;
    csrValid = 1; csrWrite = 1; csrAddr = {4'd1, 6'd0}; csrWdata = '1;
    @(negedge clk); csrValid = 0; csrWrite = 0;
    @(negedge clk);
    check("R11 drop", 64'(cpuIrq), 64'b0000);
    maskM[1] = '1;
    check("R8 clean", 64'(csrErr), 0);

    // R7: narrow accesses
    acc(0, 0, 6'd0, 4'd4, 0, rd);
    check("R7 narrow read", rd, 0);
    check("R7 err", 64'(csrErr), 1);
    acc(1, 0, 6'd0, 4'd2, 64'h55, rd);
    acc(0, 0, 6'd0, 4'd8, 0, rd);
    check("R7 mask kept", rd, maskM[0]);

    // R9: writes to read-only registers
    setReq(64'hF0);
    acc(1, 5, 6'd0, 4'd8, 64'h0, rd);
    acc(1, 8, 6'd0, 4'd8, 64'h0, rd);
    acc(0, 1, 6'd0, 4'd8, 0, rd);
    check("R9 mask kept", rd, maskM[1]);
    acc(0, 8, 6'd0, 4'd8, 0, rd);
    check("R9 raw kept", rd, 64'hF0);
    acc(0, 5, 6'd0, 4'd8, 0, rd);
    check("R9 routed kept", rd, maskM[1] & 64'hF0);

    // R10: reserved indices
    for (int i = 9; i < 16; i++) begin
      acc(0, i, 6'd0, 4'd8, 0, rd);
      check($sformatf("R10 read%0d", i), rd, 0);
      acc(1, i, 6'd0, 4'd8, 64'hDEAD, rd);
    end
    for (int n = 0; n < NCPU; n++) begin
      acc(0, n, 6'd0, 4'd8, 0, rd);
      check("R10 mask kept", rd, maskM[n]);
    end

    // R8: sticky until reset
    check("R8 still set", 64'(csrErr), 1);
    doReset();
    check("R8 cleared by reset", 64'(csrErr), 0);
    check("R1 irq after reset", 64'(cpuIrq), 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule